// File: doc/BRIEF.md
# Serial Display Command Receiver

This block is the command front end of a multiplexed display controller. A host drives three wires: an active-high select, a shift clock and a data line. While select is high, every rising edge of the shift clock moves one data bit into a 35-bit shift register. When select drops, the receiver reads the last three bits shifted in as a command code. That code decides which display latch takes the payload that arrived just before it.

Two frame kinds exist. A segment frame carries 32 segment bits followed by the 3-bit code. A brightness frame carries a 10-bit dimming value, least significant bit first, followed by the code. One code loads the same segment word into all three grid latches together. Three codes each load a single grid latch. One code loads the dimming latch, and the remaining codes change nothing. The three segment words and the dimming value go straight to the display timing logic.

All three wires are resynchronised into the system clock domain, and their edges are found there. The host must therefore hold each shift clock phase for several system clocks.

Top module: `disp_cmd_rx`

## Requirements
- R1: While reset is asserted and right after it is released, all three grid words and the dimming value read zero.
- R2: Shift clock edges that arrive while select is low shift nothing. A later select pulse with no clocks reloads the contents that were held before those edges.
- R3: A segment frame is 35 bits in transfer order: S1 to S32, then code bits C0, C1, C2. Bit Sn appears at bit n-1 of the grid word, and 1 means lit.
- R4: Code value 0 (C2C1C0 = 000) writes the segment word into all three grid latches. The dimming latch is left unchanged.
- R5: Code values 1, 2 and 3 write the segment word only into the grid 1, grid 2 or grid 3 latch respectively. Grid g occupies output bits [g*32 +: 32], with grid 1 at g = 0.
- R6: A brightness frame is 13 bits: D1 (LSB) to D10 (MSB), then C0, C1, C2. Code value 4 writes the dimming latch and leaves all grid latches unchanged.
- R7: Code values 5, 6 and 7 leave every latch unchanged.
- R8: The latches change only after select falls. During a transfer the outputs keep their previous values.
- R9: A frame longer than needed is accepted. Only the last 3 bits (the code) and the payload bits just before them count, and earlier bits are ignored.
- R10: A shift clock rise that is seen in the same system cycle as the select fall is not shifted. The load uses the bits shifted before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| sel_i | input | 1 | Transfer select, active high, asynchronous |
| sclk_i | input | 1 | Shift clock, data taken on its rising edge, asynchronous |
| sdat_i | input | 1 | Serial data, asynchronous |
| grid_seg_o | output | GRIDS*SEG_W (96) | Grid segment words, grid g at [g*SEG_W +: SEG_W] |
| dim_o | output | DIM_W (10) | Dimming value |

## Verification
Shifting and loading can meet in one system cycle. This happens when the final shift clock rise and the select fall cross the synchronisers together. The bench provokes the case by changing select, shift clock and data in the same instant at the end of a frame, with the extra bit set so that it would corrupt the code if it were taken. A correct run leaves exactly the latch picked by the intact frame updated, so a design that shifted on that edge writes the wrong latch or none.

// File: rtl/disp_cmd_pkg.sv
package disp_cmd_pkg;

  localparam int unsigned CODE_W = 3;

  typedef enum logic [CODE_W-1:0] {
    CODE_ALL_GRIDS = 3'd0,
    CODE_GRID1     = 3'd1,
    CODE_GRID2     = 3'd2,
    CODE_GRID3     = 3'd3,
    CODE_DIMMING   = 3'd4
  } cmd_code_e;

  // true when a load with this code targets grid latch g (0-based)
  function automatic logic grid_hit(input logic [CODE_W-1:0] code, input int unsigned g);
    return (code == CODE_ALL_GRIDS) || (code == CODE_W'(g + 1));
  endfunction

  function automatic logic dim_hit(input logic [CODE_W-1:0] code);
    return code == CODE_DIMMING;
  endfunction

endpackage

// File: rtl/serial_edge_sync.sv
module serial_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_i,
  input  logic sclk_i,
  input  logic sdat_i,
  output logic sel_lvl,
  output logic sdat_lvl,
  output logic sclk_rise,
  output logic sel_fall
);
  localparam int unsigned LAST = STAGES - 1;

  // bit 2 = select, bit 1 = shift clock, bit 0 = data
  logic [2:0] stg [STAGES];
  logic       sel_prev;
  logic       sclk_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < int'(STAGES); k++) stg[k] <= '0;
      sel_prev  <= 1'b0;
      sclk_prev <= 1'b0;
    end else begin
      stg[0] <= {sel_i, sclk_i, sdat_i};
      for (int k = 1; k < int'(STAGES); k++) stg[k] <= stg[k-1];
      sel_prev  <= stg[LAST][2];
      sclk_prev <= stg[LAST][1];
    end
  end

  assign sel_lvl   = stg[LAST][2];
  assign sdat_lvl  = stg[LAST][0];
  assign sclk_rise = stg[LAST][1] & ~sclk_prev;
  assign sel_fall  = ~stg[LAST][2] & sel_prev;

endmodule

// File: rtl/frame_shifter.sv
module frame_shifter #(
  parameter int unsigned FRAME_W = 35
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               shift_en,
  input  logic               bit_i,
  output logic [FRAME_W-1:0] shreg
);
  // newest bit enters at index 0
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        shreg <= '0;
    else if (shift_en) shreg <= {shreg[FRAME_W-2:0], bit_i};
  end
endmodule

// File: rtl/cmd_field_decode.sv
module cmd_field_decode
  import disp_cmd_pkg::*;
#(
  parameter int unsigned SEG_W = 32,
  parameter int unsigned DIM_W = 10,
  localparam int unsigned FRAME_W = SEG_W + CODE_W
) (
  input  logic [FRAME_W-1:0] shreg,
  output logic [CODE_W-1:0]  code,
  output logic [SEG_W-1:0]   seg_word,
  output logic [DIM_W-1:0]   dim_word
);
  // the k-th bit of a field sent LSB first sits at offset (len-1-k) above its base
  function automatic logic [CODE_W-1:0] take_code(input logic [FRAME_W-1:0] r);
    logic [CODE_W-1:0] c;
    for (int k = 0; k < int'(CODE_W); k++) c[k] = r[CODE_W-1-k];
    return c;
  endfunction

  function automatic logic [SEG_W-1:0] take_seg(input logic [FRAME_W-1:0] r);
    logic [SEG_W-1:0] s;
    for (int k = 0; k < int'(SEG_W); k++) s[k] = r[CODE_W + SEG_W - 1 - k];
    return s;
  endfunction

  function automatic logic [DIM_W-1:0] take_dim(input logic [FRAME_W-1:0] r);
    logic [DIM_W-1:0] d;
    for (int k = 0; k < int'(DIM_W); k++) d[k] = r[CODE_W + DIM_W - 1 - k];
    return d;
  endfunction

  assign code     = take_code(shreg);
  assign seg_word = take_seg(shreg);
  assign dim_word = take_dim(shreg);
endmodule

// File: rtl/disp_latch_bank.sv
module disp_latch_bank
  import disp_cmd_pkg::*;
#(
  parameter int unsigned GRIDS = 3,
  parameter int unsigned SEG_W = 32,
  parameter int unsigned DIM_W = 10
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load,
  input  logic [CODE_W-1:0]      code,
  input  logic [SEG_W-1:0]       seg_word,
  input  logic [DIM_W-1:0]       dim_word,
  output logic [GRIDS*SEG_W-1:0] grid_seg,
  output logic [DIM_W-1:0]       dim
);
  for (genvar g = 0; g < int'(GRIDS); g++) begin : g_grid
    logic [SEG_W-1:0] word_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 word_q <= '0;
      else if (load && grid_hit(code, unsigned'(g))) word_q <= seg_word;
    end
    assign grid_seg[g*SEG_W +: SEG_W] = word_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     dim <= '0;
    else if (load && dim_hit(code)) dim <= dim_word;
  end
endmodule

// File: rtl/disp_cmd_rx.sv
module disp_cmd_rx
  import disp_cmd_pkg::*;
#(
  parameter int unsigned GRIDS       = 3,
  parameter int unsigned SEG_W       = 32,
  parameter int unsigned DIM_W       = 10,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sel_i,
  input  logic                   sclk_i,
  input  logic                   sdat_i,
  output logic [GRIDS*SEG_W-1:0] grid_seg_o,
  output logic [DIM_W-1:0]       dim_o
);
  localparam int unsigned FRAME_W = SEG_W + CODE_W;

  logic               sel_lvl;
  logic               sdat_lvl;
  logic               sclk_rise;
  logic               load_stb;
  logic               shift_en;
  logic [FRAME_W-1:0] shreg;
  logic [CODE_W-1:0]  load_code;
  logic [SEG_W-1:0]   seg_word;
  logic [DIM_W-1:0]   dim_word;

  serial_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_i     (sel_i),
    .sclk_i    (sclk_i),
    .sdat_i    (sdat_i),
    .sel_lvl   (sel_lvl),
    .sdat_lvl  (sdat_lvl),
    .sclk_rise (sclk_rise),
    .sel_fall  (load_stb)
  );

  // a rise seen in the cycle select drops is discarded
  assign shift_en = sclk_rise & sel_lvl;

  frame_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (shift_en),
    .bit_i    (sdat_lvl),
    .shreg    (shreg)
  );

  cmd_field_decode #(.SEG_W(SEG_W), .DIM_W(DIM_W)) u_dec (
    .shreg    (shreg),
    .code     (load_code),
    .seg_word (seg_word),
    .dim_word (dim_word)
  );

  disp_latch_bank #(.GRIDS(GRIDS), .SEG_W(SEG_W), .DIM_W(DIM_W)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load_stb),
    .code     (load_code),
    .seg_word (seg_word),
    .dim_word (dim_word),
    .grid_seg (grid_seg_o),
    .dim      (dim_o)
  );
endmodule

// File: rtl/disp_cmd_rx_chk.sv
module disp_cmd_rx_chk #(
  parameter int unsigned GRIDS   = 3,
  parameter int unsigned SEG_W   = 32,
  parameter int unsigned DIM_W   = 10,
  parameter int unsigned FRAME_W = 35
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   sel_lvl,
  input logic                   load_stb,
  input logic                   shift_en,
  input logic [2:0]             load_code,
  input logic [FRAME_W-1:0]     shreg,
  input logic [GRIDS*SEG_W-1:0] grid_seg_o,
  input logic [DIM_W-1:0]       dim_o
);
  always_comb begin
    if (!rst_n) begin
      AST_RESET_CLEAR: assert (grid_seg_o == '0 && dim_o == '0); // R1
    end
  end

  AST_NO_SHIFT_UNSELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_lvl |=> $stable(shreg)); // R2

  AST_SHIFT_LOAD_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb |-> !shift_en); // R10

  AST_HOLD_WITHOUT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !load_stb |=> ($stable(grid_seg_o) && $stable(dim_o))); // R8

  AST_BROADCAST_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
    (load_stb && load_code == 3'd0) |=>
      (grid_seg_o[0 +: SEG_W] == grid_seg_o[SEG_W +: SEG_W]) &&
      (grid_seg_o[SEG_W +: SEG_W] == grid_seg_o[2*SEG_W +: SEG_W])); // R4

  AST_DIM_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (load_stb && load_code != 3'd4) |=> $stable(dim_o)); // R6

  AST_IDLE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (load_stb && load_code >= 3'd5) |=> ($stable(grid_seg_o) && $stable(dim_o))); // R7

  for (genvar g = 0; g < int'(GRIDS); g++) begin : g_other
    AST_OTHER_GRID_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (load_stb && load_code != 3'd0 && load_code != 3'(g + 1)) |=>
        $stable(grid_seg_o[g*SEG_W +: SEG_W])); // R5
  end
endmodule

bind disp_cmd_rx disp_cmd_rx_chk #(
  .GRIDS(GRIDS), .SEG_W(SEG_W), .DIM_W(DIM_W), .FRAME_W(FRAME_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sel_lvl    (sel_lvl),
  .load_stb   (load_stb),
  .shift_en   (shift_en),
  .load_code  (load_code),
  .shreg      (shreg),
  .grid_seg_o (grid_seg_o),
  .dim_o      (dim_o)
);

// File: tb/tb_disp_cmd_rx.sv
module tb_disp_cmd_rx;
  localparam int GRIDS = 3;
  localparam int SEG_W = 32;
  localparam int DIM_W = 10;
  localparam int HALF  = 4;   // system clocks per shift clock phase step

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel = 1'b0, sclk = 1'b0, sdat = 1'b0;
  logic [GRIDS*SEG_W-1:0] grid_seg;
  logic [DIM_W-1:0]       dim;

  logic [SEG_W-1:0] exp_g [GRIDS];
  logic [DIM_W-1:0] exp_d;
  int n_run = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  disp_cmd_rx dut (
    .clk(clk), .rst_n(rst_n), .sel_i(sel), .sclk_i(sclk), .sdat_i(sdat),
    .grid_seg_o(grid_seg), .dim_o(dim)
  );

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: run hung, actual cycle %0d expected below 190000", cyc);
      summary();
    end
  end

  task automatic check_all(input string req);
    n_run++;
    for (int g = 0; g < GRIDS; g++) begin
      if (grid_seg[g*SEG_W +: SEG_W] !== exp_g[g]) begin
        n_fail++;
        $display("FAIL %s grid%0d: actual %h expected %h", req, g + 1,
                 grid_seg[g*SEG_W +: SEG_W], exp_g[g]);
        return;
      end
    end
    if (dim !== exp_d) begin
      n_fail++;
      $display("FAIL %s dim: actual %h expected %h", req, dim, exp_d);
    end
  endtask

  function automatic logic [47:0] seg_frame(input logic [31:0] w, input logic [2:0] c);
    return {13'd0, c, w};
  endfunction

  function automatic logic [47:0] dim_frame(input logic [9:0] d, input logic [2:0] c);
    return {35'd0, c, d};
  endfunction

  // model of the latch update, from the code table in the requirements
  task automatic model(input logic [2:0] c, input logic [31:0] w, input logic [9:0] d);
    case (c)
      3'd0: for (int g = 0; g < GRIDS; g++) exp_g[g] = w;
      3'd1: exp_g[0] = w;
      3'd2: exp_g[1] = w;
      3'd3: exp_g[2] = w;
      3'd4: exp_d = d;
      default: ;
    endcase
  endtask

  task automatic send_bit(input logic b);
    sdat = b;  wait_clk(HALF);
    sclk = 1'b1; wait_clk(HALF);
    sclk = 1'b0; wait_clk(HALF);
  endtask

  // fb[0] goes first; mid: check outputs before select drops; tail: clock an extra 1 with the drop
  task automatic xfer(input logic [47:0] fb, input int n, input bit mid, input bit tail);
    sel = 1'b1; wait_clk(HALF);
    for (int i = 0; i < n; i++) send_bit(fb[i]);
    if (mid) check_all("R8");
    if (tail) begin
      sdat = 1'b1; sclk = 1'b1; sel = 1'b0;
      wait_clk(HALF);
      sclk = 1'b0;
    end else begin
      sel = 1'b0;
    end
    wait_clk(3 * HALF);
  endtask

  initial begin
    logic [31:0] w;
    logic [9:0]  d;
    for (int g = 0; g < GRIDS; g++) exp_g[g] = '0;
    exp_d = '0;
    wait_clk(3);
    check_all("R1");
    rst_n = 1'b1;
    wait_clk(3);
    check_all("R1");

    // R4: broadcast code 0
    w = 32'hA5C3_0F81;
    xfer(seg_frame(w, 3'd0), 35, 1'b0, 1'b0); model(3'd0, w, '0);
    check_all("R4");

    // R5: single grid codes, several patterns
    for (int c = 1; c <= 3; c++) begin
      for (int p = 0; p < 3; p++) begin
        w = (p == 0) ? 32'hFFFF_FFFF : (p == 1) ? 32'h0000_0000 : (32'h1357_9BDF ^ (c * 32'h1111_0000));
        xfer(seg_frame(w, 3'(c)), 35, 1'b0, 1'b0); model(3'(c), w, '0);
        check_all("R5");
      end
    end

    // R3: walking one through every segment position, into grid 2
    for (int n = 0; n < SEG_W; n++) begin
      w = 32'd1 << n;
      xfer(seg_frame(w, 3'd2), 35, 1'b0, 1'b0); model(3'd2, w, '0);
      check_all("R3");
    end

    // R6: dimming sweep, grids must stay
    for (int v = 0; v < 1024; v += 97) begin
      d = 10'(v);
      xfer(dim_frame(d, 3'd4), 13, 1'b0, 1'b0); model(3'd4, '0, d);
      check_all("R6");
    end
    d = 10'h3FF; xfer(dim_frame(d, 3'd4), 13, 1'b0, 1'b0); model(3'd4, '0, d); check_all("R6");
    d = 10'h001; xfer(dim_frame(d, 3'd4), 13, 1'b0, 1'b0); model(3'd4, '0, d); check_all("R6");

    // R7: idle codes, segment and dimming shaped frames
    for (int c = 5; c <= 7; c++) begin
      xfer(seg_frame(32'hDEAD_BEEF, 3'(c)), 35, 1'b0, 1'b0);
      check_all("R7");
      xfer(dim_frame(10'h2AA, 3'(c)), 13, 1'b0, 1'b0);
      check_all("R7");
    end

    // R8: outputs unchanged until select falls
    w = 32'h0F0F_1234;
    xfer(seg_frame(w, 3'd0), 35, 1'b1, 1'b0); model(3'd0, w, '0);
    check_all("R8");

    // R9: leading junk bits ignored
    w = 32'h8000_0001;
    xfer({seg_frame(w, 3'd3)[42:0], 5'b10111}, 40, 1'b0, 1'b0); model(3'd3, w, '0);
    check_all("R9");

    // R2: clocks while unselected are ignored; empty select pulse reloads old contents
    w = 32'h7777_0001;
    xfer(seg_frame(w, 3'd1), 35, 1'b0, 1'b0); model(3'd1, w, '0);
    begin
      logic [47:0] junk;
      junk = seg_frame(32'h0BAD_F00D, 3'd1);
      for (int i = 0; i < 35; i++) send_bit(junk[i]);
    end
    check_all("R2");
    sel = 1'b1; wait_clk(3 * HALF); sel = 1'b0; wait_clk(3 * HALF);
    check_all("R2");

    // R10: final rise coincides with the select fall and must be dropped
    w = 32'h3C3C_A0A0;
    xfer(seg_frame(w, 3'd2), 35, 1'b0, 1'b1); model(3'd2, w, '0);
    check_all("R10");
    w = 32'h0000_FFFF;
    xfer(dim_frame(10'h155, 3'd4), 13, 1'b0, 1'b1); model(3'd4, '0, 10'h155);
    check_all("R10");

    done = 1;
    summary();
  end
endmodule